// File: doc/BRIEF.md
# 4B/5B Receive Symbol Decoder

This block sits behind the descrambler of a 100 Mb/s receive path. It takes one recovered line bit per clock and looks for the two-group start-of-stream delimiter. Once it finds the delimiter it locks 5-bit code-group alignment at that bit position. From then on it turns each code-group back into a nibble and drives carrier sense, receive-data-valid and receive-error flags in the style of a media-independent interface.

Outputs change once per symbol period, at the clock marked by `sym_stb_o`, and hold between updates. The decoder always has the next code-group available when it judges the current one. This lets it drop data-valid on the first group of a clean end delimiter, so the delimiter never appears as data. Malformed delimiters, stray control groups, invalid groups and an idle run inside a frame are all reported as receive errors. After the frame closes, alignment is dropped and the search starts again.

Top module: `rx4b5b_dec`

## Requirements
- R1: Line bits enter MSB-first, one per clock. While not aligned, the block locks on the clock where the last ten received bits equal 1100010001 (J = 11000 then K = 10001). This works at any bit offset.
- R2: The lock produces an update with nibble 0101 and carrier and data-valid both rising. The next update carries K, also as 0101. Data-valid is never high while carrier is low.
- R3: Inside a frame the data groups decode as 0:11110 1:01001 2:10100 3:10101 4:01010 5:01011 6:01110 7:01111 8:10010 9:10011 A:10110 B:10111 C:11010 D:11011 E:11100 F:11101. Each is reported with data-valid high and the error flag low.
- R4: While aligned there is exactly one update strobe every five clocks, and the flags and nibble change only on strobe clocks. A code-group's update appears five clocks after the clock that samples its last bit.
- R5: T (01101) directly followed by R (00111) closes the frame. The T update has carrier high and data-valid low. The R update has carrier low, and the block then returns to searching.
- R6: A T not followed by R, or an R not preceded by T, gives an update with the error flag and data-valid high.
- R7: H (00100) and the invalid groups 00000, 00001, 00010, 00011, 00101, 00110, 01000, 01100, 10000, 11001 raise the error flag inside a frame.
- R8: J or K arriving after the start delimiter raises the error flag inside a frame.
- R9: Two consecutive idle groups (11111) inside a frame end it. The update for the first idle has carrier and data-valid low and the error flag high, for one update only, and searching resumes. A single idle followed by a non-idle raises the error flag with data-valid high.
- R10: The nibble output is 0000 whenever data-valid is low or the error flag is high.
- R11: Reset (rst_ni low) clears alignment, carrier, data-valid, error flag and strobe at once. A frame cut by reset does not resume.
- R12: While searching there are no updates, and a J not followed by K does not lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_bit_i | input | 1 | Recovered line bit |
| rx_nib_o | output | 4 | Decoded nibble |
| crs_o | output | 1 | Carrier sense |
| rx_dv_o | output | 1 | Receive data valid |
| rx_er_o | output | 1 | Receive error |
| sym_stb_o | output | 1 | One-clock pulse marking each update |

## Verification
The cases that are hardest to reach from the ports are the delimiter misuse cases. A T whose successor is not R, an R with no T before it, and a lone idle all have to be placed mid-frame in a known code-group phase. Otherwise the decoder never sees them aligned. The stimulus table therefore opens each error frame with a clean J/K and then places the misplaced control groups back to back. It finishes with an idle pair to exercise the premature close.

A separate frame is preceded by three loose bits. This proves the lock follows the delimiter rather than a fixed phase.

// File: rtl/rx4b5b_pkg.sv
package rx4b5b_pkg;
  localparam int SYM_W = 5;
  localparam int NIB_W = 4;
  localparam int WIN_W = 2 * SYM_W;
  localparam int PH_W  = $clog2(SYM_W);
  localparam int N_DATA = 1 << NIB_W;

  localparam logic [SYM_W-1:0] C_IDLE = 5'b11111;
  localparam logic [SYM_W-1:0] C_J    = 5'b11000;
  localparam logic [SYM_W-1:0] C_K    = 5'b10001;
  localparam logic [SYM_W-1:0] C_T    = 5'b01101;
  localparam logic [SYM_W-1:0] C_R    = 5'b00111;
  localparam logic [NIB_W-1:0] NIB_SSD = 4'b0101;

  typedef enum logic [2:0] {
    K_DATA, K_IDLE, K_J, K_K, K_T, K_R, K_BAD
  } kind_e;

  typedef enum logic [1:0] {
    S_HUNT, S_GOT_J, S_DATA, S_END
  } fsm_e;

  function automatic logic [SYM_W-1:0] enc_nib(input logic [NIB_W-1:0] n);
    logic [SYM_W-1:0] c;
    case (n)
      4'h0: c = 5'b11110;
      4'h1: c = 5'b01001;
      4'h2: c = 5'b10100;
      4'h3: c = 5'b10101;
      4'h4: c = 5'b01010;
      4'h5: c = 5'b01011;
      4'h6: c = 5'b01110;
      4'h7: c = 5'b01111;
      4'h8: c = 5'b10010;
      4'h9: c = 5'b10011;
      4'hA: c = 5'b10110;
      4'hB: c = 5'b10111;
      4'hC: c = 5'b11010;
      4'hD: c = 5'b11011;
      4'hE: c = 5'b11100;
      default: c = 5'b11101;
    endcase
    return c;
  endfunction

  function automatic logic is_data(input logic [SYM_W-1:0] c);
    logic hit;
    hit = 1'b0;
    for (int n = 0; n < N_DATA; n++)
      if (enc_nib(NIB_W'(n)) == c) hit = 1'b1;
    return hit;
  endfunction

  function automatic logic [NIB_W-1:0] dec_nib(input logic [SYM_W-1:0] c);
    logic [NIB_W-1:0] v;
    v = '0;
    for (int n = 0; n < N_DATA; n++)
      if (enc_nib(NIB_W'(n)) == c) v = NIB_W'(n);
    return v;
  endfunction

  function automatic kind_e dec_kind(input logic [SYM_W-1:0] c);
    kind_e k;
    if (is_data(c))       k = K_DATA;
    else if (c == C_IDLE) k = K_IDLE;
    else if (c == C_J)    k = K_J;
    else if (c == C_K)    k = K_K;
    else if (c == C_T)    k = K_T;
    else if (c == C_R)    k = K_R;
    else                  k = K_BAD;
    return k;
  endfunction
endpackage

// File: rtl/rx4b5b_align.sv
module rx4b5b_align
  import rx4b5b_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_i,
  input  logic             drop_i,
  output logic [SYM_W-1:0] cur_o,
  output logic [SYM_W-1:0] nxt_o,
  output logic             bnd_o,
  output logic             hit_o
);
  localparam logic [WIN_W-1:0] SSD_PAT = {C_J, C_K};
  localparam logic [PH_W-1:0]  PH_LAST = PH_W'(SYM_W - 1);

  logic [WIN_W-1:0] sh_q;
  logic [WIN_W-1:0] win;
  logic             locked_q;
  logic [PH_W-1:0]  ph_q;

  assign win   = {sh_q[WIN_W-2:0], bit_i};
  assign hit_o = !locked_q && (win == SSD_PAT);
  assign bnd_o = locked_q && (ph_q == PH_LAST);
  assign cur_o = win[WIN_W-1 -: SYM_W];
  assign nxt_o = win[SYM_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q     <= '0;
      locked_q <= 1'b0;
      ph_q     <= '0;
    end else begin
      sh_q <= win;
      if (hit_o) begin
        locked_q <= 1'b1;
        ph_q     <= '0;
      end else if (locked_q) begin
        if (drop_i) locked_q <= 1'b0;
        ph_q <= bnd_o ? '0 : ph_q + 1'b1;
      end
    end
  end

  a_r1_lock_on_ssd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_q) |-> $past(win) == SSD_PAT);

  a_r4_one_bnd_per_symbol: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bnd_o |=> !bnd_o);

  a_r12_drop_only_at_bnd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_i |-> bnd_o);
endmodule

// File: rtl/rx4b5b_symdec.sv
module rx4b5b_symdec
  import rx4b5b_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic [SYM_W-1:0] code_i [LANES],
  output kind_e            kind_o [LANES],
  output logic [NIB_W-1:0] nib_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign kind_o[g] = dec_kind(code_i[g]);
  end

  assign nib_o = dec_nib(code_i[0]);
endmodule

// File: rtl/rx4b5b_fsm.sv
module rx4b5b_fsm
  import rx4b5b_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  input  logic             bnd_i,
  input  kind_e            cur_kind_i,
  input  kind_e            nxt_kind_i,
  input  logic [NIB_W-1:0] cur_nib_i,
  output logic             drop_o,
  output logic [NIB_W-1:0] nib_o,
  output logic             crs_o,
  output logic             dv_o,
  output logic             er_o,
  output logic             stb_o
);
  fsm_e             st_q, st_d;
  logic [NIB_W-1:0] nib_d;
  logic             crs_d, dv_d, er_d, emit;

  always_comb begin
    st_d   = st_q;
    nib_d  = nib_o;
    crs_d  = crs_o;
    dv_d   = dv_o;
    er_d   = er_o;
    emit   = 1'b0;
    drop_o = 1'b0;
    if (hit_i) begin
      emit  = 1'b1;
      nib_d = NIB_SSD;
      crs_d = 1'b1;
      dv_d  = 1'b1;
      er_d  = 1'b0;
      st_d  = S_GOT_J;
    end else if (bnd_i) begin
      emit  = 1'b1;
      nib_d = '0;
      crs_d = 1'b1;
      dv_d  = 1'b1;
      er_d  = 1'b1;
      case (st_q)
        S_GOT_J: begin
          nib_d = NIB_SSD;
          er_d  = 1'b0;
          st_d  = S_DATA;
        end
        S_DATA: begin
          case (cur_kind_i)
            K_DATA: begin
              nib_d = cur_nib_i;
              er_d  = 1'b0;
            end
            K_T: if (nxt_kind_i == K_R) begin
              dv_d = 1'b0;
              er_d = 1'b0;
              st_d = S_END;
            end
            K_IDLE: if (nxt_kind_i == K_IDLE) begin
              crs_d  = 1'b0;
              dv_d   = 1'b0;
              st_d   = S_HUNT;
              drop_o = 1'b1;
            end
            default: ;
          endcase
        end
        S_END: begin
          crs_d  = 1'b0;
          dv_d   = 1'b0;
          er_d   = 1'b0;
          st_d   = S_HUNT;
          drop_o = 1'b1;
        end
        default: begin
          emit  = 1'b0;
          nib_d = nib_o;
          crs_d = crs_o;
          dv_d  = dv_o;
          er_d  = er_o;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= S_HUNT;
      nib_o <= '0;
      crs_o <= 1'b0;
      dv_o  <= 1'b0;
      er_o  <= 1'b0;
      stb_o <= 1'b0;
    end else begin
      st_q  <= st_d;
      nib_o <= nib_d;
      crs_o <= crs_d;
      dv_o  <= dv_d;
      er_o  <= er_d;
      stb_o <= emit;
    end
  end

  a_r2_dv_needs_crs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dv_o |-> crs_o);

  a_r2_frame_opens_ssd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dv_o) |-> (nib_o == NIB_SSD) && !er_o && stb_o);

  a_r4_hold_between: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_o |-> $stable({nib_o, crs_o, dv_o, er_o}));

  a_r4_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_o |=> !stb_o);

  a_r5_crs_falls_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(crs_o) |-> !dv_o);

  a_r10_nib_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dv_o || er_o) |-> nib_o == '0);

  a_r12_no_hit_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |-> st_q == S_HUNT);
endmodule

// File: rtl/rx4b5b_dec.sv
module rx4b5b_dec
  import rx4b5b_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_bit_i,
  output logic [NIB_W-1:0] rx_nib_o,
  output logic             crs_o,
  output logic             rx_dv_o,
  output logic             rx_er_o,
  output logic             sym_stb_o
);
  localparam int LANES = 2;

  logic [SYM_W-1:0] code [LANES];
  kind_e            kind [LANES];
  logic [NIB_W-1:0] cur_nib;
  logic             bnd, hit, drop;

  rx4b5b_align u_align (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bit_i  (rx_bit_i),
    .drop_i (drop),
    .cur_o  (code[0]),
    .nxt_o  (code[1]),
    .bnd_o  (bnd),
    .hit_o  (hit)
  );

  rx4b5b_symdec #(.LANES(LANES)) u_symdec (
    .code_i (code),
    .kind_o (kind),
    .nib_o  (cur_nib)
  );

  rx4b5b_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hit_i      (hit),
    .bnd_i      (bnd),
    .cur_kind_i (kind[0]),
    .nxt_kind_i (kind[1]),
    .cur_nib_i  (cur_nib),
    .drop_o     (drop),
    .nib_o      (rx_nib_o),
    .crs_o      (crs_o),
    .dv_o       (rx_dv_o),
    .er_o       (rx_er_o),
    .stb_o      (sym_stb_o)
  );
endmodule

// File: tb/sim_rx4b5b_dec.sv
module sim_rx4b5b_dec;
  localparam time CLK_P = 20ns;
  localparam int  NV    = 46;
  localparam int  MAXR  = 96;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rx_bit_i = 1'b1;
  logic [3:0] rx_nib_o;
  logic       crs_o, rx_dv_o, rx_er_o, sym_stb_o;

  int n_chk = 0, n_fail = 0, cyc = 0, nrec = 0;
  logic [6:0] rec  [MAXR];
  int         rcyc [MAXR];

  rx4b5b_dec u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .rx_bit_i(rx_bit_i),
    .rx_nib_o(rx_nib_o), .crs_o(crs_o), .rx_dv_o(rx_dv_o),
    .rx_er_o(rx_er_o), .sym_stb_o(sym_stb_o)
  );

  always #(CLK_P/2) clk_i = ~clk_i;

  // row: code, emit, nibble, crs, dv, er, requirement number
  localparam logic [16:0] VEC [NV] = '{
    // clean frame: R2 R3 R5
    {5'b11111,1'b0,4'h0,3'b000,4'd12},
    {5'b11111,1'b0,4'h0,3'b000,4'd12},
    {5'b11111,1'b0,4'h0,3'b000,4'd12},
    {5'b11111,1'b0,4'h0,3'b000,4'd12},
    {5'b11000,1'b1,4'h5,3'b110,4'd2},
    {5'b10001,1'b1,4'h5,3'b110,4'd2},
    {5'b11110,1'b1,4'h0,3'b110,4'd3},
    {5'b01001,1'b1,4'h1,3'b110,4'd3},
    {5'b10100,1'b1,4'h2,3'b110,4'd3},
    {5'b10101,1'b1,4'h3,3'b110,4'd3},
    {5'b01010,1'b1,4'h4,3'b110,4'd3},
    {5'b01011,1'b1,4'h5,3'b110,4'd3},
    {5'b01110,1'b1,4'h6,3'b110,4'd3},
    {5'b01111,1'b1,4'h7,3'b110,4'd3},
    {5'b10010,1'b1,4'h8,3'b110,4'd3},
    {5'b10011,1'b1,4'h9,3'b110,4'd3},
    {5'b10110,1'b1,4'hA,3'b110,4'd3},
    {5'b10111,1'b1,4'hB,3'b110,4'd3},
    {5'b11010,1'b1,4'hC,3'b110,4'd3},
    {5'b11011,1'b1,4'hD,3'b110,4'd3},
    {5'b11100,1'b1,4'hE,3'b110,4'd3},
    {5'b11101,1'b1,4'hF,3'b110,4'd3},
    {5'b01101,1'b1,4'h0,3'b100,4'd5},
    {5'b00111,1'b1,4'h0,3'b000,4'd5},
    {5'b11111,1'b0,4'h0,3'b000,4'd12},
    {5'b11111,1'b0,4'h0,3'b000,4'd12},
    {5'b11111,1'b0,4'h0,3'b000,4'd12},
    // error frame: R6 R7 R8 R9 R10
    {5'b11111,1'b0,4'h0,3'b000,4'd12},
    {5'b11111,1'b0,4'h0,3'b000,4'd12},
    {5'b11000,1'b1,4'h5,3'b110,4'd2},
    {5'b10001,1'b1,4'h5,3'b110,4'd2},
    {5'b10101,1'b1,4'h3,3'b110,4'd3},
    {5'b00000,1'b1,4'h0,3'b111,4'd7},
    {5'b10110,1'b1,4'hA,3'b110,4'd3},
    {5'b10001,1'b1,4'h0,3'b111,4'd8},
    {5'b00100,1'b1,4'h0,3'b111,4'd7},
    {5'b01101,1'b1,4'h0,3'b111,4'd6},
    {5'b01011,1'b1,4'h5,3'b110,4'd3},
    {5'b00111,1'b1,4'h0,3'b111,4'd6},
    {5'b11000,1'b1,4'h0,3'b111,4'd8},
    {5'b11111,1'b1,4'h0,3'b111,4'd9},
    {5'b01111,1'b1,4'h7,3'b110,4'd3},
    {5'b11111,1'b1,4'h0,3'b001,4'd9},
    {5'b11111,1'b0,4'h0,3'b000,4'd12},
    {5'b11111,1'b0,4'h0,3'b000,4'd12},
    {5'b11111,1'b0,4'h0,3'b000,4'd12}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk_i);
    rx_bit_i = b;
  endtask

  task automatic send_sym(input logic [4:0] c);
    for (int i = 4; i >= 0; i--) send_bit(c[i]);
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(posedge clk_i);
    #1;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      cyc++;
      if (sym_stb_o && nrec < MAXR) begin
        rec[nrec]  = {rx_nib_o, crs_o, rx_dv_o, rx_er_o};
        rcyc[nrec] = cyc;
        nrec++;
      end
    end
  end

  initial begin
    #(CLK_P * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int k, base;
    wait_clk(3);
    // R11: reset state
    check("R11 reset", {28'd0, crs_o, rx_dv_o, rx_er_o, sym_stb_o}, 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) send_sym(VEC[i][16:12]);
    for (int i = 0; i < 4; i++) send_sym(5'b11111);
    wait_clk(8);

    k = 0;
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][11]) begin
        check($sformatf("R%0d vec%0d", VEC[i][3:0], i), {25'd0, rec[k]}, {25'd0, VEC[i][10:4]});
        k++;
      end
    end
    check("R12 update count", nrec, k);

    // R1: lock at an arbitrary bit offset; R4 cadence
    base = nrec;
    for (int i = 0; i < 3; i++) send_bit(1'b1);
    send_sym(5'b11111);
    send_sym(5'b11000);
    send_sym(5'b10001);
    send_sym(5'b10011);
    send_sym(5'b01101);
    send_sym(5'b00111);
    send_sym(5'b11111);
    send_sym(5'b11111);
    wait_clk(6);
    check("R1 offset lock count", nrec - base, 5);
    check("R1 J update", {25'd0, rec[base]}, {25'd0, 4'h5, 3'b110});
    check("R3 nibble 9", {25'd0, rec[base+2]}, {25'd0, 4'h9, 3'b110});
    check("R5 T update", {25'd0, rec[base+3]}, {25'd0, 4'h0, 3'b100});
    check("R5 R update", {25'd0, rec[base+4]}, {25'd0, 4'h0, 3'b000});
    for (int i = 1; i < 5; i++)
      check("R4 cadence", rcyc[base+i] - rcyc[base+i-1], 5);

    // R12: J without K and a lone K do not lock
    base = nrec;
    send_sym(5'b11111);
    send_sym(5'b11000);
    send_sym(5'b11111);
    send_sym(5'b10001);
    send_sym(5'b11111);
    send_sym(5'b11111);
    wait_clk(6);
    check("R12 no lock", nrec - base, 0);
    check("R12 idle outputs", {28'd0, crs_o, rx_dv_o, rx_er_o, sym_stb_o}, 32'd0);

    // R11: reset mid-frame clears, frame does not resume
    send_sym(5'b11111);
    send_sym(5'b11000);
    send_sym(5'b10001);
    send_sym(5'b10010);
    wait_clk(1);
    check("R2 frame open", {30'd0, crs_o, rx_dv_o}, 32'd3);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R11 async clear", {28'd0, crs_o, rx_dv_o, rx_er_o, sym_stb_o}, 32'd0);
    wait_clk(3);
    @(negedge clk_i);
    rst_ni = 1'b1;
    base = nrec;
    send_sym(5'b01001);
    send_sym(5'b10100);
    send_sym(5'b11111);
    send_sym(5'b11111);
    wait_clk(6);
    check("R11 no resume", nrec - base, 0);
    check("R11 outputs low", {28'd0, crs_o, rx_dv_o, rx_er_o, sym_stb_o}, 32'd0);

    finish_run();
  end
endmodule